// File: doc/BRIEF.md
# Static Memory Bus Controller

This block sits between a simple host port and an external asynchronous memory bus with four chip selects. The host issues one 32-bit read or write at a time. The controller decodes the chip select from the top address bits and looks up that chip select's configuration. It then drives the external strobes for a programmed number of cycles and answers the host with a one-cycle ready pulse. Devices narrower than 32 bits are served by a run of back-to-back external accesses. The bytes or halfwords are placed on the low data lanes and assembled little-endian.

Each chip select has an 8-bit configuration register. It holds a wait-state code, a synchronous/asynchronous flag, a write-enable flag and a device-width code. The synchronous flag is kept for software and has no effect on timing. A separate register port reaches these registers. A key register guards every configuration write: writing the key value unlocks the block, and writing any other value locks it again.

Top module: `static_mem_ctrl`

## Requirements
- R1: The chip select is `host_addr[HAW-1:HAW-2]`. During an access only that bit of `ext_cs` is high, and at most one bit of `ext_cs` is ever high.
- R2: Configuration bits [7:4] hold a wait code n. Every external access keeps `ext_cs` high for min(n+2, 16) cycles, so codes 14 and 15 both give 16 cycles.
- R3: Configuration bits [1:0] set the device width: 00 is 8-bit (four beats), 01 is 16-bit (two beats), 10 or 11 is 32-bit (one beat). `ext_addr` is `{word, beat}` for 8-bit, `{0, word, beat[0]}` for 16-bit and `{00, word}` for 32-bit, with word = `host_addr[HAW-3:2]`. Beat k uses the low lanes of `ext_wdata`/`ext_rdata` and maps to bits starting at k times the lane width of the host word.
- R4: Configuration bit 2 is the write enable. A write to a chip select whose bit 2 is 0 raises no `ext_cs`, `ext_oe` or `ext_we`. It ends with `host_ready` and `host_err` both high in the cycle after the request is taken. A read from such a chip select completes normally with `host_err` low.
- R5: Configuration bit 3 (1 = synchronous) is stored and read back unchanged. It does not change the access timing.
- R6: Writing 0xA05F to register offset 0x20 unlocks the block, and any other value written there locks it. Reading offset 0x20 returns 1 while locked and 0 while unlocked.
- R7: A configuration write at offset 0x00, 0x04, 0x08 or 0x0C (chip select 0 to 3) made while locked is ignored, and the register keeps its value.
- R8: `host_ready` is a one-cycle pulse in the cycle after the last external access ends, and `host_rdata` holds the assembled read word in that cycle.
- R9: After reset every configuration register reads 0xF0 and the lock register reads 1.
- R10: A read asserts `ext_oe` and never `ext_we`, and a write asserts `ext_we` and never `ext_oe`. Either strobe is high only while a chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the offset of the previous cycle |
| host_req | input | 1 | Host request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HAW | Host byte address; the top two bits pick the chip select |
| host_wdata | input | DW | Host write word |
| host_rdata | output | DW | Read word, valid with `host_ready` |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Error flag, valid with `host_ready` |
| ext_cs | output | NUM_CS | Active-high chip selects |
| ext_oe | output | 1 | Output enable (read strobe) |
| ext_we | output | 1 | Write strobe |
| ext_addr | output | HAW-2 | Device-unit address |
| ext_wdata | output | DW | External write data, low lanes used for narrow devices |
| ext_rdata | input | DW | External read data |

## Verification
The bench builds the block with HAW = 10, so the chip select is `host_addr[9:8]` and `ext_addr` is 8 bits wide. NUM_CS = 4, DW = 32 and the 16-cycle cap keep their default values. With so few address bits, a sweep can pair every wait code with every width code, spread over all four chip selects, and check the strobe length and the data of each pair. It also covers the reset defaults, the lock key and wrong keys, ignored writes while locked, and the error path for write-disabled chip selects.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef struct packed {
    logic [3:0] wait_code;
    logic       sync;
    logic       wr_en;
    logic [1:0] width;
  } cs_cfg_t;

  localparam cs_cfg_t     CFG_RESET  = 8'hF0;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DONE} acc_state_t;

  function automatic int access_cycles(input logic [3:0] code, input int cap);
    int c;
    c = int'(code) + 2;
    return (c > cap) ? cap : c;
  endfunction

  function automatic logic [1:0] last_beat_of(input logic [1:0] width);
    case (width)
      2'b00:   return 2'd3;
      2'b01:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int RAW      = 6,
  parameter int RDW      = 16,
  parameter int LOCK_OFS = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  output cs_cfg_t        cfg_o [NUM_CS]
);

  logic locked;
  logic [RDW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b1;
    else if (reg_we && reg_addr == RAW'(LOCK_OFS)) locked <= (reg_wdata != UNLOCK_KEY);
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cfg_o[i] <= CFG_RESET;
      else if (reg_we && !locked && reg_addr == RAW'(i * 4)) cfg_o[i] <= reg_wdata[7:0];
    end

    // R7: locked writes leave the register untouched
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
      (reg_we && locked && reg_addr == RAW'(i * 4)) |=> $stable(cfg_o[i]));
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (reg_addr == RAW'(i * 4)) rd_next = {{(RDW-8){1'b0}}, cfg_o[i]};
    if (reg_addr == RAW'(LOCK_OFS)) rd_next = {{(RDW-1){1'b0}}, locked};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R6: the key unlocks, any other value locks
  a_r6_key_unlocks: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RAW'(LOCK_OFS) && reg_wdata == UNLOCK_KEY) |=> !locked);
  a_r6_other_locks: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RAW'(LOCK_OFS) && reg_wdata != UNLOCK_KEY) |=> locked);

endmodule

// File: rtl/smc_beat_lanes.sv
module smc_beat_lanes #(
  parameter int DW = 32
) (
  input  logic [1:0]    width,
  input  logic [1:0]    beat,
  input  logic [DW-1:0] wword,
  input  logic [DW-1:0] lane_in,
  input  logic [DW-1:0] acc_in,
  output logic [DW-1:0] lane_out,
  output logic [DW-1:0] acc_out
);

  localparam int Q = DW / 4;
  localparam int H = DW / 2;

  always_comb begin
    lane_out = '0;
    acc_out  = acc_in;
    case (width)
      2'b00: begin
        lane_out[Q-1:0]        = wword[beat*Q +: Q];
        acc_out[beat*Q +: Q]   = lane_in[Q-1:0];
      end
      2'b01: begin
        lane_out[H-1:0]          = wword[beat[0]*H +: H];
        acc_out[beat[0]*H +: H]  = lane_in[H-1:0];
      end
      default: begin
        lane_out = wword;
        acc_out  = lane_in;
      end
    endcase
  end

endmodule

// File: rtl/smc_access_fsm.sv
module smc_access_fsm
  import smc_pkg::*;
#(
  parameter int HAW     = 16,
  parameter int DW      = 32,
  parameter int NUM_CS  = 4,
  parameter int MAX_CYC = 16,
  localparam int CSW    = $clog2(NUM_CS),
  localparam int EAW    = HAW - CSW
) (
  input  logic              clk,
  input  logic              rst,
  input  cs_cfg_t           cfg [NUM_CS],
  input  logic              host_req,
  input  logic              host_we,
  input  logic [HAW-1:0]    host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_ready,
  output logic              host_err,
  output logic [NUM_CS-1:0] ext_cs,
  output logic              ext_oe,
  output logic              ext_we,
  output logic [EAW-1:0]    ext_addr,
  output logic [DW-1:0]     ext_wdata,
  input  logic [DW-1:0]     ext_rdata
);

  localparam int CW  = $clog2(MAX_CYC + 1);
  localparam int WAW = EAW - 2;

  acc_state_t     state;
  logic [CSW-1:0] cur_cs, req_cs;
  logic           cur_we, err_q;
  logic [1:0]     cur_width, beat, last_beat;
  logic [CW-1:0]  cur_cyc, cnt, sel_cyc;
  logic [WAW-1:0] word_addr;
  logic [DW-1:0]  wdata_q, acc_q, acc_next, rdata_q;
  cs_cfg_t        sel;

  assign req_cs  = host_addr[HAW-1 -: CSW];
  assign sel     = cfg[req_cs];
  assign sel_cyc = CW'(access_cycles(sel.wait_code, MAX_CYC));

  smc_beat_lanes #(.DW(DW)) u_lanes (
    .width   (cur_width),
    .beat    (beat),
    .wword   (wdata_q),
    .lane_in (ext_rdata),
    .acc_in  (acc_q),
    .lane_out(ext_wdata),
    .acc_out (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_cs    <= '0;
      cur_we    <= 1'b0;
      cur_width <= 2'b00;
      cur_cyc   <= '0;
      cnt       <= '0;
      beat      <= 2'd0;
      last_beat <= 2'd0;
      word_addr <= '0;
      wdata_q   <= '0;
      acc_q     <= '0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (host_req) begin
          cur_cs    <= req_cs;
          cur_we    <= host_we;
          cur_width <= sel.width;
          cur_cyc   <= sel_cyc;
          cnt       <= sel_cyc - 1'b1;
          beat      <= 2'd0;
          last_beat <= last_beat_of(sel.width);
          word_addr <= host_addr[HAW-CSW-1:2];
          wdata_q   <= host_wdata;
          acc_q     <= '0;
          rdata_q   <= '0;
          if (host_we && !sel.wr_en) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            err_q <= 1'b0;
            state <= S_ACC;
          end
        end
        S_ACC: begin
          if (cnt == '0) begin
            acc_q <= acc_next;
            if (beat == last_beat) begin
              state   <= S_DONE;
              rdata_q <= cur_we ? '0 : acc_next;
            end else begin
              beat <= beat + 2'd1;
              cnt  <= cur_cyc - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ext_cs = '0;
    if (state == S_ACC) ext_cs[cur_cs] = 1'b1;
    case (cur_width)
      2'b00:   ext_addr = {word_addr, beat};
      2'b01:   ext_addr = {1'b0, word_addr, beat[0]};
      default: ext_addr = {2'b00, word_addr};
    endcase
  end

  assign ext_oe     = (state == S_ACC) && !cur_we;
  assign ext_we     = (state == S_ACC) && cur_we;
  assign host_ready = (state == S_DONE);
  assign host_err   = host_ready && err_q;
  assign host_rdata = rdata_q;

  // R1: never more than one chip select
  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(ext_cs));
  // R10: strobes are exclusive and only inside a chip select window
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst) !(ext_oe && ext_we));
  a_r10_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (ext_oe || ext_we) |-> (ext_cs != '0));
  // R8: completion is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst) host_ready |=> !host_ready);
  // R4: an error completion follows a cycle with no bus activity
  a_r4_err_no_bus: assert property (@(posedge clk) disable iff (rst)
    host_err |-> ($past(ext_cs) == '0));
  // R2: the cycle counter stays inside the programmed window
  a_r2_cnt_window: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACC) |-> (cnt < cur_cyc));

endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl
  import smc_pkg::*;
#(
  parameter int HAW     = 16,
  parameter int DW      = 32,
  parameter int NUM_CS  = 4,
  parameter int MAX_CYC = 16,
  localparam int EAW    = HAW - $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [HAW-1:0]    host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_ready,
  output logic              host_err,
  output logic [NUM_CS-1:0] ext_cs,
  output logic              ext_oe,
  output logic              ext_we,
  output logic [EAW-1:0]    ext_addr,
  output logic [DW-1:0]     ext_wdata,
  input  logic [DW-1:0]     ext_rdata
);

  cs_cfg_t cfg [NUM_CS];

  smc_cfg_regs #(.NUM_CS(NUM_CS), .RAW(6), .RDW(16), .LOCK_OFS(32)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cfg_o    (cfg)
  );

  smc_access_fsm #(.HAW(HAW), .DW(DW), .NUM_CS(NUM_CS), .MAX_CYC(MAX_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .host_req  (host_req),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .host_ready(host_ready),
    .host_err  (host_err),
    .ext_cs    (ext_cs),
    .ext_oe    (ext_oe),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_rdata (ext_rdata)
  );

endmodule

// File: tb/static_mem_ctrl_bench.sv
module static_mem_ctrl_bench;

  localparam int HAW = 10;
  localparam int DW  = 32;
  localparam int EAW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [5:0]      reg_addr = '0;
  logic [15:0]     reg_wdata = '0;
  logic [15:0]     reg_rdata;
  logic            host_req = 1'b0;
  logic            host_we = 1'b0;
  logic [HAW-1:0]  host_addr = '0;
  logic [DW-1:0]   host_wdata = '0;
  logic [DW-1:0]   host_rdata;
  logic            host_ready, host_err;
  logic [3:0]      ext_cs;
  logic            ext_oe, ext_we;
  logic [EAW-1:0]  ext_addr;
  logic [DW-1:0]   ext_wdata, ext_rdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  static_mem_ctrl #(.HAW(HAW), .DW(DW), .NUM_CS(4), .MAX_CYC(16)) u_static_mem_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .host_err(host_err), .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [31:0] mdl(input int cs, input logic [7:0] a);
    return {a + 8'h31, a ^ 8'h5A, ~a, a + 8'(cs * 64)};
  endfunction

  always_comb begin
    int ci;
    ci = 0;
    for (int i = 0; i < 4; i++) if (ext_cs[i]) ci = i;
    ext_rdata = mdl(ci, ext_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic access(input int cs, input bit we, input logic [5:0] word,
                        input logic [31:0] wd, input logic [3:0] code,
                        input logic [1:0] w, input bit exp_err, input string tag);
    int cyc, beats, u, base, n, cs_cnt, bad_cs, bad_strobe, idx;
    bit done;
    logic [31:0] cap, exp, m;
    cyc   = (int'(code) + 2 > 16) ? 16 : int'(code) + 2;
    beats = (w == 2'b00) ? 4 : (w == 2'b01) ? 2 : 1;
    u     = 32 / beats;
    base  = int'(word) * beats;
    cap = '0; n = 0; cs_cnt = 0; bad_cs = 0; bad_strobe = 0; done = 1'b0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = {2'(cs), word, 2'b00}; host_wdata = wd;
    while (!done) begin
      @(negedge clk);
      n++;
      if (host_ready) done = 1'b1;
      else begin
        if (ext_cs != 4'b0) begin
          cs_cnt++;
          if (ext_cs != (4'b1 << cs)) bad_cs++;
          if (we ? (!ext_we || ext_oe) : (!ext_oe || ext_we)) bad_strobe++;
          if (ext_we) begin
            idx = int'(ext_addr) - base;
            if (idx >= 0 && idx < beats)
              for (int b = 0; b < u; b++) cap[idx*u + b] = ext_wdata[b];
          end
        end else if (ext_oe || ext_we) bad_strobe++;
        if (n > 400) begin
          done = 1'b1;
          chk(1'b0, "R8", {tag, " ready timeout"}, 32'(n), 32'(cyc * beats));
        end
      end
    end
    host_req = 1'b0;
    chk(host_err == exp_err, "R4", {tag, " error flag"}, 32'(host_err), 32'(exp_err));
    if (exp_err) begin
      chk(cs_cnt == 0 && bad_strobe == 0, "R4", {tag, " no bus on refused write"},
          32'(cs_cnt), 32'd0);
    end else begin
      chk(cs_cnt == cyc * beats, "R2", {tag, " strobe cycles"}, 32'(cs_cnt), 32'(cyc * beats));
      chk(bad_cs == 0, "R1", {tag, " chip select"}, 32'(bad_cs), 32'd0);
      chk(bad_strobe == 0, "R10", {tag, " strobe kind"}, 32'(bad_strobe), 32'd0);
      if (we) begin
        chk(cap == wd, "R3", {tag, " write lanes"}, cap, wd);
      end else begin
        exp = '0;
        for (int k = 0; k < beats; k++) begin
          m = mdl(cs, 8'(base + k));
          for (int b = 0; b < u; b++) exp[k*u + b] = m[b];
        end
        chk(host_rdata == exp, "R3", {tag, " read assembly"}, host_rdata, exp);
        chk(n == cyc * beats + 1, "R8", {tag, " ready timing"}, 32'(n), 32'(cyc * beats + 1));
      end
    end
  endtask

  initial begin
    logic [15:0] rv;
    logic [7:0]  val;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    for (int i = 0; i < 4; i++) begin
      rd_reg(6'(i * 4), rv);
      chk(rv == 16'h00F0, "R9", "reset config", 32'(rv), 32'h00F0);
    end
    rd_reg(6'h20, rv);
    chk(rv == 16'h0001, "R9", "reset lock", 32'(rv), 32'h1);

    // Defaults: 16 cycles, 8-bit, write disabled
    access(0, 1'b0, 6'h05, 32'h0, 4'hF, 2'b00, 1'b0, "R2 reset read");
    access(1, 1'b1, 6'h05, 32'h12345678, 4'hF, 2'b00, 1'b1, "R4 reset write");

    // R7: locked write ignored
    wr_reg(6'h00, 16'h0006);
    rd_reg(6'h00, rv);
    chk(rv == 16'h00F0, "R7", "locked write ignored", 32'(rv), 32'h00F0);

    // R6: wrong key keeps locked, right key unlocks
    wr_reg(6'h20, 16'h1234);
    rd_reg(6'h20, rv);
    chk(rv == 16'h0001, "R6", "wrong key", 32'(rv), 32'h1);
    wr_reg(6'h20, 16'hA05F);
    rd_reg(6'h20, rv);
    chk(rv == 16'h0000, "R6", "key unlocks", 32'(rv), 32'h0);

    // Sweep every wait code against every width code
    for (int code = 0; code < 16; code++) begin
      for (int w = 0; w < 4; w++) begin
        int cs;
        cs  = (code + w) % 4;
        val = {4'(code), 1'(code), 1'b1, 2'(w)};
        wr_reg(6'(cs * 4), {8'h00, val});
        rd_reg(6'(cs * 4), rv);
        chk(rv == {8'h00, val}, "R5", "config readback incl sync flag", 32'(rv), 32'(val));
        access(cs, 1'b0, 6'(code * 4 + w), 32'h0, 4'(code), 2'(w), 1'b0, "R2 R3 sweep read");
        access(cs, 1'b1, 6'(code * 3 + w), 32'hC0DE0000 + 32'(code * 256 + w * 17),
               4'(code), 2'(w), 1'b0, "R3 sweep write");
      end
    end

    // R4: write-disabled chip select refuses writes, serves reads
    wr_reg(6'h08, 16'h0031);
    access(2, 1'b1, 6'h11, 32'hDEADBEEF, 4'h3, 2'b01, 1'b1, "R4 disabled write");
    access(2, 1'b0, 6'h11, 32'h0, 4'h3, 2'b01, 1'b0, "R4 disabled read");

    // R5: same timing with sync flag set or clear
    wr_reg(6'h0C, 16'h005E);
    access(3, 1'b0, 6'h2A, 32'h0, 4'h5, 2'b10, 1'b0, "R5 sync set");
    wr_reg(6'h0C, 16'h0056);
    access(3, 1'b0, 6'h2A, 32'h0, 4'h5, 2'b10, 1'b0, "R5 sync clear");

    // R6/R7: relock and check write is dropped
    wr_reg(6'h20, 16'h0000);
    rd_reg(6'h20, rv);
    chk(rv == 16'h0001, "R6", "relock", 32'(rv), 32'h1);
    wr_reg(6'h0C, 16'h00A1);
    rd_reg(6'h0C, rv);
    chk(rv == 16'h0056, "R7", "relocked write ignored", 32'(rv), 32'h0056);
    access(3, 1'b0, 6'h07, 32'h0, 4'h5, 2'b10, 1'b0, "R7 timing unchanged");

    summary();
    $finish;
  end

endmodule